// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the synchronous slave side of a 2 KB byte-wide serial memory on a two-wire bus. A system clock oversamples the bus clock and data lines. The engine finds start and stop conditions and gathers bits into bytes. It decodes the select byte, which carries the three upper memory address bits, and then runs the byte-address and data phases. It acknowledges by pulling the data line low through an output enable, and it streams read data out one byte after another.

An 11-bit address counter feeds reads and writes. Read data comes from a small register-array memory model. Write bytes go to a separate write controller, which holds up to one 16-byte row. On a stop condition the controller starts a timed program cycle. While that cycle runs the engine ignores the bus completely, so a bus master can poll with select bytes until one is acknowledged.

Top module: `twi_mem_slave`

## Requirements
- R1: A command begins only with a start condition, which is the data line falling while the clock line is high. Bytes clocked without a preceding start get no acknowledge.
- R2: A select byte whose upper nibble (bits 7..4) is not 1010 gets no acknowledge. The engine then stays silent for every further byte until the next start.
- R3: In an accepted select byte, bits 3..1 load address bits 10..8 of the counter. Bit 0 is the direction, with 1 meaning read. The byte-address byte that follows a write select loads address bits 7..0.
- R4: The engine pulls the data line low during the ninth clock of every byte it accepts: the select byte, the byte address and each write data byte. It changes its drive only while the clock line is low.
- R5: Each write data byte is stored at the counter. Only counter bits 3..0 advance, so the bytes wrap inside one 16-byte row. Memory changes only after the stop condition that ends the write.
- R6: A write select plus byte address followed by a repeated start writes nothing and starts no program cycle. A read select after it returns the byte at the address that was just loaded.
- R7: A read select returns the byte at the counter (upper bits taken from the select) and then advances the counter by one.
- R8: When the master acknowledges a read byte, the engine sends the next byte. The counter wraps from 7FFh to 000h.
- R9: When the master does not acknowledge a read byte, the engine releases the data line and drives nothing until the next start. After reset it drives nothing.
- R10: A stop that ends a write carrying data starts a program cycle of PROG_CYCLES clocks. During that cycle start conditions and select bytes are ignored and get no acknowledge. Afterwards a select is acknowledged again.
- R11: A start arriving part-way through a byte discards the partial bits. The next eight bits are decoded as a fresh select byte.
- R12: After reset every memory byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired value) |
| sda_oe_o | output | 1 | When high, the pin pulls the data line low |

## Verification
On every cycle the assertions check several rules. The data-line drive changes only while the synchronized clock is low. Nothing is driven while idle. An acknowledged select always holds the 1010 code. A program cycle keeps the engine idle with no write pushes, and it begins only after a commit. Pushed write bytes keep the row of the address counter. Other behaviour can only be shown by the bench's bus scenarios: the returned data values, row wrap, top-of-memory wrap, the dummy write that leaves memory unchanged, the polling sequence that moves from no acknowledge to acknowledge, and recovery from a start in the middle of a byte.

// File: rtl/twi_mem_pkg.sv
// Shared constants and state encodings for the two-wire memory slave.
package twi_mem_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RX_ACK,
        S_TX,
        S_TX_ACK
    } eng_state_t;

    typedef enum logic [1:0] {
        P_DEV,
        P_ADDR,
        P_DATA
    } rx_phase_t;
endpackage

// File: rtl/twi_bus_sync.sv
// Synchronizes the bus clock and data lines into clk and flags clock edges,
// start and stop conditions. Assumes the bus is much slower than clk and
// SYNC_STAGES >= 2. Both lines reset to the idle-high level.
module twi_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_d;
    logic                   sda_d;

    // Shift the raw lines through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
            scl_d <= scl_q[SYNC_STAGES-1];
            sda_d <= sda_q[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_q[SYNC_STAGES-1];
    assign sda_s     = sda_q[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_mem_array.sv
// Register-array stand-in for the storage cells. Combinational read,
// synchronous write, and every byte set to all ones by reset.
module twi_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Erase to all ones on reset, otherwise accept one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/twi_write_ctrl.sv
// Collects write bytes for one row, then runs a timed program cycle after a
// commit. During the cycle it copies valid row entries into the memory, one
// per clock, and reports busy. Assumes PROG_CYCLES > row size.
module twi_write_ctrl #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int PROG_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [7:0]        push_data,
    input  logic              commit,
    input  logic              discard,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata
);
    localparam int PAGE  = 1 << PAGE_W;
    localparam int ROW_W = ADDR_W - PAGE_W;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [7:0]       row_data [PAGE];
    logic [PAGE-1:0]  row_vld;
    logic [ROW_W-1:0] row_sel;
    logic [CNT_W-1:0] cnt;
    logic             busy_q;

    // One storage register per row entry, loaded when its slot is pushed.
    for (genvar g = 0; g < PAGE; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push && !busy_q && push_addr[PAGE_W-1:0] == PAGE_W'(g))
                row_data[g] <= push_data;
        end
    end

    // Track valid entries, the row and the program-cycle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_vld <= '0;
            row_sel <= '0;
            cnt     <= '0;
            busy_q  <= 1'b0;
        end else if (busy_q) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(PROG_CYCLES - 1)) begin
                busy_q  <= 1'b0;
                row_vld <= '0;
            end
        end else if (commit && |row_vld) begin
            busy_q <= 1'b1;
            cnt    <= '0;
        end else if (commit || discard) begin
            row_vld <= '0;
        end else if (push) begin
            row_vld[push_addr[PAGE_W-1:0]] <= 1'b1;
            row_sel <= push_addr[ADDR_W-1:PAGE_W];
        end
    end

    assign busy      = busy_q;
    assign mem_we    = busy_q && (cnt < CNT_W'(PAGE)) && row_vld[cnt[PAGE_W-1:0]];
    assign mem_waddr = {row_sel, cnt[PAGE_W-1:0]};
    assign mem_wdata = row_data[cnt[PAGE_W-1:0]];

    assert_busy_after_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(commit));
    assert_no_push_in_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !push);
endmodule

// File: rtl/twi_mem_slave.sv
// Two-wire bus slave engine for a 2 KB memory. It decodes the select byte
// (code 1010, three upper address bits, direction), the byte address and the
// data bytes, drives acknowledge and read data through an active-high pull
// enable, and hands write bytes to the write controller. It assumes the bus
// runs many clk cycles per bit and that ADDR_W is between 9 and 11.
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int PROG_CYCLES = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam int BLK_W = ADDR_W - 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    eng_state_t        state;
    rx_phase_t         phase;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [7:0]        txreg;
    logic [ADDR_W-1:0] addr_cnt;
    logic              rw_q;
    logic              m_ack;
    logic              sda_oe;
    logic              push, commit, discard;
    logic [ADDR_W-1:0] push_addr;
    logic [7:0]        push_data;
    logic              wc_busy;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        rd_data;

    twi_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_write_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_wctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr),
        .push_data(push_data), .commit(commit), .discard(discard), .busy(wc_busy),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(addr_cnt), .rdata(rd_data)
    );

    // Bus protocol engine: conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            phase     <= P_DEV;
            bit_cnt   <= '0;
            shreg     <= '0;
            txreg     <= '0;
            addr_cnt  <= '0;
            rw_q      <= 1'b0;
            m_ack     <= 1'b0;
            sda_oe    <= 1'b0;
            push      <= 1'b0;
            commit    <= 1'b0;
            discard   <= 1'b0;
            push_addr <= '0;
            push_data <= '0;
        end else begin
            push    <= 1'b0;
            commit  <= 1'b0;
            discard <= 1'b0;
            if (start_det) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                phase   <= P_DEV;
                if (wc_busy) begin
                    state <= S_IDLE;
                end else begin
                    state   <= S_RX;
                    discard <= 1'b1;
                end
            end else if (stop_det) begin
                commit <= (state != S_IDLE) && (phase == P_DATA);
                state  <= S_IDLE;
                phase  <= P_DEV;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    S_RX: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            case (phase)
                                P_DEV: begin
                                    if (shreg[7:4] == DEV_CODE) begin
                                        addr_cnt[ADDR_W-1:8] <= shreg[BLK_W:1];
                                        rw_q   <= shreg[0];
                                        sda_oe <= 1'b1;
                                        state  <= S_RX_ACK;
                                    end else begin
                                        state <= S_IDLE;
                                    end
                                end
                                P_ADDR: begin
                                    addr_cnt[7:0] <= shreg;
                                    sda_oe <= 1'b1;
                                    state  <= S_RX_ACK;
                                end
                                default: begin
                                    push      <= 1'b1;
                                    push_addr <= addr_cnt;
                                    push_data <= shreg;
                                    addr_cnt[PAGE_W-1:0] <= addr_cnt[PAGE_W-1:0] + 1'b1;
                                    sda_oe <= 1'b1;
                                    state  <= S_RX_ACK;
                                end
                            endcase
                        end
                    end
                    S_RX_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (phase == P_DEV && rw_q) begin
                                txreg    <= rd_data;
                                addr_cnt <= addr_cnt + 1'b1;
                                sda_oe   <= ~rd_data[7];
                                state    <= S_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= S_RX;
                                phase  <= (phase == P_DEV) ? P_ADDR : P_DATA;
                            end
                        end
                    end
                    S_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= S_TX_ACK;
                            end else begin
                                txreg  <= {txreg[6:0], 1'b0};
                                sda_oe <= ~txreg[6];
                            end
                        end
                    end
                    S_TX_ACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (m_ack) begin
                                txreg    <= rd_data;
                                addr_cnt <= addr_cnt + 1'b1;
                                sda_oe   <= ~rd_data[7];
                                state    <= S_TX;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = sda_oe;

    assert_drive_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);
    assert_deaf_in_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wc_busy |-> (state == S_IDLE));
    assert_select_ack_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RX_ACK && phase == P_DEV) |-> (shreg[7:4] == DEV_CODE));
    assert_push_keeps_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_addr[ADDR_W-1:PAGE_W] == addr_cnt[ADDR_W-1:PAGE_W]));
endmodule

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
    localparam int Q    = 10;
    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    logic [7:0] exp_q [$];
    string      req_q [$];
    logic [7:0] got_byte;
    event       got_ev;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    twi_mem_slave #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        acked = (sda_bus == 1'b0);
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    // Driver side of the scoreboard: queue an expected read byte.
    task automatic expect_rd(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        req_q.push_back(req);
    endtask

    task automatic recv_byte(input bit master_ack);
        logic [7:0] v;
        v = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q); scl_m = 1'b1; tick(Q);
            v = {v[6:0], sda_bus};
            tick(Q); scl_m = 1'b0;
        end
        sda_m = ~master_ack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
        got_byte = v;
        -> got_ev;
    endtask

    // Monitor side of the scoreboard: compare each received byte in order.
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                chk("scoreboard", 1, 0);
            end else begin
                chk(req_q.pop_front(), int'(got_byte), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic write_bytes(input logic [2:0] blk, input logic [7:0] a,
                               input logic [7:0] d [4], input int n);
        bit ack;
        bus_start();
        send_byte({4'b1010, blk, 1'b0}, ack); chk("R4 select ack", int'(ack), 1);
        send_byte(a, ack);                    chk("R4 address ack", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], ack);             chk("R4 data ack", int'(ack), 1);
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [2:0] blk, input logic [7:0] a, input int n);
        bit ack;
        bus_start();
        send_byte({4'b1010, blk, 1'b0}, ack); chk("R6 dummy select ack", int'(ack), 1);
        send_byte(a, ack);                    chk("R6 dummy address ack", int'(ack), 1);
        bus_start();
        send_byte({4'b1010, blk, 1'b1}, ack); chk("R6 read select ack", int'(ack), 1);
        for (int k = 0; k < n; k++) recv_byte(k < n - 1);
        bus_stop();
    endtask

    task automatic poll(input logic [2:0] blk, input int exp_ack, input string req);
        bit ack;
        bus_start();
        send_byte({4'b1010, blk, 1'b0}, ack);
        chk(req, int'(ack), exp_ack);
        bus_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        bit ack;
        logic [7:0] d [4];
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R9 released after reset", int'(sda_oe), 0);

        // R1: a select byte clocked without a start is ignored.
        scl_m = 1'b0; tick(Q);
        send_byte(8'hA1, ack); chk("R1 no start no ack", int'(ack), 0);
        bus_stop();

        // R2: wrong code, then silence for the next byte too.
        bus_start();
        send_byte(8'h51, ack); chk("R2 wrong code nack", int'(ack), 0);
        send_byte(8'hA1, ack); chk("R2 silent until start", int'(ack), 0);
        bus_stop();

        // R12: erased content.
        expect_rd(8'hFF, "R12 erased byte");
        rand_read(3'd4, 8'h00, 1);

        // Byte write, then polling during the program cycle (R10).
        d = '{8'h5A, 8'h00, 8'h00, 8'h00};
        write_bytes(3'd3, 8'h25, d, 1);
        poll(3'd3, 0, "R10 no ack while programming");
        tick(PROG + 50);
        poll(3'd3, 1, "R10 ack after program cycle");

        // R3 / R6: random read of the block/address just written, then no cycle started.
        expect_rd(8'h5A, "R3 random read data");
        rand_read(3'd3, 8'h25, 1);
        poll(3'd3, 1, "R6 dummy write starts no cycle");

        // R5: four bytes from row offset Eh wrap inside the row.
        d = '{8'h11, 8'h22, 8'h33, 8'h44};
        write_bytes(3'd1, 8'h1E, d, 4);
        tick(PROG + 50);
        expect_rd(8'h11, "R5 row byte 0");
        expect_rd(8'h22, "R5 row byte 1");
        expect_rd(8'hFF, "R5 next row untouched");
        rand_read(3'd1, 8'h1E, 3);
        expect_rd(8'h33, "R5 wrapped byte 2");
        expect_rd(8'h44, "R5 wrapped byte 3");
        rand_read(3'd1, 8'h10, 2);

        // R8: sequential read wraps from the top of memory to address 0.
        d = '{8'h3C, 8'h77, 8'h00, 8'h00};
        write_bytes(3'd0, 8'h00, d, 2);
        tick(PROG + 50);
        d = '{8'hC1, 8'hC2, 8'h00, 8'h00};
        write_bytes(3'd7, 8'hFE, d, 2);
        tick(PROG + 50);
        expect_rd(8'hC1, "R8 byte 7FEh");
        expect_rd(8'hC2, "R8 byte 7FFh");
        expect_rd(8'h3C, "R8 wrapped to 000h");
        rand_read(3'd7, 8'hFE, 3);

        // R7: current-address read continues at 001h, then 002h.
        expect_rd(8'h77, "R7 current read 001h");
        bus_start();
        send_byte(8'hA1, ack); chk("R7 select ack", int'(ack), 1);
        recv_byte(1'b0);
        bus_stop();
        expect_rd(8'hFF, "R7 current read 002h");
        bus_start();
        send_byte(8'hA1, ack); chk("R7 second select ack", int'(ack), 1);
        recv_byte(1'b0);

        // R9: after the master's NACK the data line stays released.
        for (int i = 0; i < 9; i++) begin
            tick(Q); scl_m = 1'b1; tick(Q);
            chk("R9 released after nack", int'(sda_bus), 1);
            tick(Q); scl_m = 1'b0; tick(Q);
        end
        bus_stop();

        // R11: a start after three bits restarts select decoding.
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        expect_rd(8'hFF, "R11 read after restart");
        bus_start();
        send_byte(8'hA1, ack); chk("R11 select after partial byte", int'(ack), 1);
        recv_byte(1'b0);
        bus_stop();

        tick(20);
        chk("scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule